// File: doc/BRIEF.md
# Triggered Asynchronous Serial Transmitter

This block turns one byte into an asynchronous serial frame: a low start bit, the eight data bits least significant first, an optional parity bit, and one or two high stop bits. Software first loads the byte into a holding register. It then writes a one to the trigger input to launch the frame. While the frame is on the line, the trigger reads back as busy. The configuration (parity on or off, odd or even parity, stop-bit count) is captured when the frame is launched.

Bit timing comes from an external timer strobe. Inside the block, a 16-step counter turns the strobes into a sampling clock and marks its rising and falling phases with single-cycle enables. Each bit goes onto the line at a falling phase. The transmit-complete interrupt is a one-cycle pulse. It is raised at the first rising phase after the final stop bit has been driven, in the same cycle that busy clears.

Top module: `uart_tx_trig`

## Requirements
- R1: After reset, and whenever no frame is in progress, tx_o is high, busy_o is 0 and irq_done_o is 0.
- R2: A trigger write (trig_wr_i high for one cycle) while tx_en_i is 1 and busy_o is 0 sets busy_o to 1 on the next cycle. tx_o stays high until the first falling phase after that.
- R3: A trigger write while tx_en_i is 0 is ignored: busy_o stays 0 and no frame appears.
- R4: The sampling counter starts at 0 on reset and advances on each tick_i strobe. Counting from 0 since reset, the strobe with index 16k+15 is a falling phase and the strobe with index 16k+7 is a rising phase. tx_o changes only in the cycle after a falling phase.
- R5: The frame order is start bit (0), then data bits 0 through 7 (bit 0 first), then the optional parity bit, then the stop bits (1).
- R6: When par_en_i is 1, a parity bit is sent. For even parity (par_odd_i = 0) it makes the count of ones across data and parity even. For odd parity (par_odd_i = 1) it makes that count odd. When par_en_i is 0, no parity slot is sent.
- R7: two_stop_i = 1 sends two stop bits and two_stop_i = 0 sends one.
- R8: irq_done_o pulses for exactly one cycle, in the cycle after the first rising phase that follows the driving of the last stop bit. busy_o returns to 0 in that same cycle.
- R9: A trigger write while busy_o is 1 is ignored. A data write while busy_o is 1 does not change the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| par_en_i | input | 1 | Parity slot enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| data_wr_i | input | 1 | Write strobe for the holding register |
| data_i | input | 8 | Byte to load |
| trig_wr_i | input | 1 | Write of a one to the trigger bit |
| tick_i | input | 1 | Timer strobe, one cycle wide |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Trigger readback, 1 while a frame is active |
| irq_done_o | output | 1 | Transmit-complete pulse |

## Verification
A trigger shows up on busy_o one clock later. A tick that lands on a falling phase moves tx_o one clock later, and a tick that lands on the closing rising phase raises irq_done_o one clock later. The bench issues every strobe for exactly one clock. It then samples at the following falling clock edge, so each result is read in the cycle it becomes due. It keeps its own count of strobes since reset to predict which strobe is a falling or a rising phase. For every strobe of a frame it compares the line, busy and the interrupt against a frame it built itself, and it checks one cycle after the pulse that the interrupt has dropped again.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_END  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uart_tx_sclk.sv
module uart_tx_sclk #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // sampling clock high in upper half; phase enables are single-cycle
  assign rise_o = tick_i && (cnt_q == HALF);
  assign fall_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int DATA_W = 8,
  parameter int FRM_W  = DATA_W + 4,
  parameter int CNT_W  = $clog2(FRM_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic [FRM_W-1:0]  frame_o,
  output logic [CNT_W-1:0]  len_o
);
  logic par_bit;

  assign par_bit = par_odd_i ? ~^data_i : ^data_i;
  // slots above data default to 1 so omitted parity falls through to stop
  assign frame_o = {2'b11, (par_en_i ? par_bit : 1'b1), data_i, 1'b0};
  assign len_o   = CNT_W'(DATA_W + 2) + CNT_W'(par_en_i) + CNT_W'(two_stop_i);
endmodule

// File: rtl/uart_tx_trig.sv
module uart_tx_trig
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              trig_wr_i,
  input  logic              tick_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              irq_done_o
);
  localparam int FRM_W = DATA_W + 4;
  localparam int CNT_W = $clog2(FRM_W + 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] hold_q;
  logic [FRM_W-1:0]  shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              tx_q;
  logic              irq_q;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [FRM_W-1:0]  frame;
  logic [CNT_W-1:0]  frame_len;

  uart_tx_sclk #(.DIV(DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .FRM_W(FRM_W), .CNT_W(CNT_W)) u_frame (
    .data_i     (hold_q),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .frame_o    (frame),
    .len_o      (frame_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (data_wr_i) hold_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '1;
      left_q  <= '0;
      tx_q    <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_wr_i && tx_en_i) begin
            shreg_q <= frame;
            left_q  <= frame_len;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (sclk_fall) begin
            tx_q    <= shreg_q[0];
            shreg_q <= {1'b1, shreg_q[FRM_W-1:1]};
            left_q  <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) state_q <= ST_END;
          end
        end
        ST_END: begin
          if (sclk_rise) begin
            irq_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_o       = tx_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign irq_done_o = irq_q;
endmodule

// File: rtl/uart_tx_trig_chk.sv
module uart_tx_trig_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic trig_wr_i,
  input logic tx_o,
  input logic busy_o,
  input logic irq_done_o,
  input logic rise_i,
  input logic fall_i
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o); // R1
  AST_TRIG_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr_i && tx_en_i && !busy_o) |=> busy_o); // R2
  AST_TRIG_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_wr_i && !tx_en_i && !busy_o) |=> !busy_o); // R3
  AST_LINE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != $past(tx_o)) |-> $past(fall_i)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o); // R8
  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_done_o) |-> ($past(rise_i) && $past(busy_o) && !busy_o)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rise_i) |=> busy_o); // R9
endmodule

bind uart_tx_trig uart_tx_trig_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .trig_wr_i  (trig_wr_i),
  .tx_o       (tx_o),
  .busy_o     (busy_o),
  .irq_done_o (irq_done_o),
  .rise_i     (sclk_rise),
  .fall_i     (sclk_fall)
);

// File: tb/uart_tx_trig_tb.sv
module uart_tx_trig_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic       two_stop_i = 1'b0;
  logic       data_wr_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       trig_wr_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       tx_o;
  logic       busy_o;
  logic       irq_done_o;

  int n_chk  = 0;
  int n_fail = 0;
  int tick_n = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  uart_tx_trig u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .par_en_i(par_en_i),
    .par_odd_i(par_odd_i), .two_stop_i(two_stop_i), .data_wr_i(data_wr_i),
    .data_i(data_i), .trig_wr_i(trig_wr_i), .tick_i(tick_i), .tx_o(tx_o),
    .busy_o(busy_o), .irq_done_o(irq_done_o)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_tick();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
    tick_n++;
  endtask

  task automatic write_data(input logic [7:0] d);
    @(negedge clk_i) begin data_wr_i = 1'b1; data_i = d; end
    @(negedge clk_i) data_wr_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk_i) trig_wr_i = 1'b1;
    @(negedge clk_i) trig_wr_i = 1'b0;
  endtask

  task automatic idle_ticks(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      do_tick();
      chk(req, tx_o, 1);
      chk(req, busy_o, 0);
      chk(req, irq_done_o, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 reset tx", tx_o, 1);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset irq", irq_done_o, 0);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic pe, input logic po,
                         input logic two, input bit mid);
    logic bits[12];
    int n, idx, p;
    logic line;
    bit done, mid_done;
    string req;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    n = 9;
    if (pe) begin bits[n] = po ? ~^d : ^d; n++; end
    bits[n] = 1'b1; n++;
    if (two) begin bits[n] = 1'b1; n++; end
    @(negedge clk_i) begin tx_en_i = 1'b1; par_en_i = pe; par_odd_i = po; two_stop_i = two; end
    write_data(d);
    pulse_trig();
    chk("R2 busy after trigger", busy_o, 1);
    chk("R2 line high before fall", tx_o, 1);
    line = 1'b1; idx = 0; done = 0; mid_done = 0;
    for (int k = 0; k < 400 && !done; k++) begin
      p = tick_n % 16;
      do_tick();
      if (p == 15 && idx < n) begin line = bits[idx]; idx++; end
      if (p == 7 && idx == n) begin
        chk("R8 irq at rise", irq_done_o, 1);
        chk("R8 busy clears", busy_o, 0);
        done = 1;
      end else begin
        chk("R8 no early irq", irq_done_o, 0);
        chk("R2 busy held", busy_o, 1);
      end
      if (idx <= 9 && !(pe && idx == 10)) req = "R4 R5 bit";
      if (pe && idx == 10) req = "R6 parity";
      if (idx > (pe ? 10 : 9)) req = "R7 stop";
      chk(req, tx_o, line);
      if (mid && !mid_done && idx == 5) begin
        write_data(~d);
        pulse_trig();
        chk("R9 busy kept", busy_o, 1);
        chk("R9 line kept", tx_o, line);
        mid_done = 1;
      end
    end
    chk("R8 frame completed", done, 1);
    @(negedge clk_i);
    chk("R8 irq one cycle", irq_done_o, 0);
    chk("R1 idle after frame", tx_o, 1);
  endtask

  task automatic t_disabled();
    @(negedge clk_i) tx_en_i = 1'b0;
    write_data(8'h5A);
    pulse_trig();
    chk("R3 busy stays low", busy_o, 0);
    idle_ticks(40, "R3 no frame");
    @(negedge clk_i) tx_en_i = 1'b1;
  endtask

  task automatic t_busy_trig();
    t_frame(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1);
    idle_ticks(40, "R9 no second frame");
  endtask

  task automatic t_reset_mid();
    write_data(8'h00);
    pulse_trig();
    for (int k = 0; k < 40; k++) do_tick();
    chk("R1 mid frame busy", busy_o, 1);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    chk("R1 reset line", tx_o, 1);
    chk("R1 reset busy", busy_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    tick_n = 0;
    idle_ticks(20, "R1 idle after reset");
    t_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_frame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    t_frame(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0);
    t_frame(8'h07, 1'b1, 1'b1, 1'b0, 1'b0);
    t_frame(8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
    t_frame(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    t_disabled();
    t_busy_trig();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule